// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt sources of a small 8-bit processor and presents one request at a time to the CPU. Each source has a vector pair at a fixed address.

**Sources**
- One boot request, armed by reset.
- Seven pin inputs. Each pin has its own choice of rising or falling edge.
- Eight single-cycle event pulses from on-chip peripherals.
- A software break request. It cannot be masked.

**Pending, enable and mask**
- Every maskable source has a pending bit and an enable bit.
- A global mask flag holds back all maskable sources.
- Software can clear pending bits through a small register bus but can never set them.

**Service**
- The block always shows the winning source's vector on `vec_addr` while `irq` is high.
- A one-cycle `cpu_ack` accepts that source. Acceptance clears its pending state and sets the mask flag, so the next service needs software to lower the flag again.
- Stacking and the vector fetch are left to the CPU.

**Edge selection side effect**
The edge choice is applied to the synchronized pin level before edge detection. Flipping the edge choice while the pin is at the level that the new choice treats as "after the edge" therefore registers a request. Software must clear that request after changing the selection.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Maskable sources are numbered 1 to 15, with lower numbers winning:
  - 1: pin 0
  - 2: pin 1
  - 3: event 0
  - 4: event 1
  - 5: event 2
  - 6: event 3
  - 7: event 4
  - 8: event 5
  - 9: pin 2
  - 10: pin 3
  - 11: event 6
  - 12: pin 4
  - 13: pin 5
  - 14: pin 6
  - 15: event 7

  Source k has pending and enable bit k-1 (bits 0–7 in the low register, bits 8–14 in bits 0–6 of the high register). The vector is 0xFFFC − 2·k.
- R2: `irq` is high for a maskable source only when its pending bit is 1, its enable bit is 1 and the mask flag (bit 0 of register 5) is 0. With no boot or break request pending, `irq` is low otherwise.
- R3: A bus write to register 0 or 1 clears each pending bit whose data bit is 0 and leaves bits written with 1 unchanged. No write ever sets a pending bit. Register map:
  - 0: pending, low byte
  - 1: pending, high byte
  - 2: enable, low byte
  - 3: enable, high byte
  - 4: edge select
  - 5: mask flag
- R4: A `brk_req` pulse makes a break pending. It is served ahead of every maskable source, ignoring the mask flag and all enable bits, with vector 0xFFDE.
- R5: `cpu_ack` while `irq` is high accepts the shown source:
  - its pending state clears on that edge;
  - the mask flag becomes 1, overriding a same-cycle write to it.

  `cpu_ack` while `irq` is low has no effect.
- R6: Edge-select bit p (register 4) chooses a rising (0) or falling (1) edge on pin p. A qualifying pin change sets the pending bit on the third rising clock edge after it, not the second. The opposite transition sets nothing.
- R7: Writing an edge-select bit so that the current synchronized pin level looks like a new edge sets that source's pending bit on the clock edge after the write.
- R8: Bit 7 of registers 1 and 3 always reads 0, even after writing 1.
- R9: After reset:
  - pending, enable and edge-select bits are 0;
  - the mask flag is 1;
  - a boot request is pending, so `irq` is 1 with vector 0xFFFC.

  The boot request outranks all others and is cleared by its acknowledge.
- R10: A peripheral pulse sets its pending bit on the next clock edge, even when a clearing write to the same bit happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_pin | input | 7 | Asynchronous pin inputs |
| periph_evt | input | 8 | Single-cycle peripheral event pulses |
| brk_req | input | 1 | Software break pulse |
| cpu_ack | input | 1 | One-cycle acknowledge of the shown source |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector low-byte address of the winning source |

## Verification
A corrupted pending or enable bit appears on `irq` and `vec_addr` in the same cycle, because both are decoded combinationally from registered state. It is also visible on the next read of the register. A lost mask-flag update shows up as an `irq` that stays high, or never rises, immediately after an acknowledge or a write to register 5. A fault in the synchronizer or edge logic shifts the pending bit away from the third clock edge after the pin change, so the bench samples both the second and third edge.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int NUM_SRC   = 16;
    localparam int SRC_W     = 4;
    localparam int REQ_W     = NUM_SRC - 1;
    localparam int NUM_PIN   = 7;
    localparam int NUM_EVT   = 8;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int VEC_W     = 16;
    localparam int SYNC_DEPTH = 2;

    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;
    localparam logic [SRC_W-1:0] BRK_SLOT = SRC_W'(NUM_SRC - 1);

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND_LO = 3'd0,
        REG_PEND_HI = 3'd1,
        REG_ENA_LO  = 3'd2,
        REG_ENA_HI  = 3'd3,
        REG_EDGE    = 3'd4,
        REG_MASK    = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             is_boot;
        logic             is_brk;
        logic [SRC_W-1:0] idx;
    } pick_t;

    // source number served by a pin input
    function automatic int pin_src(input int p);
        case (p)
            0:       return 1;
            1:       return 2;
            2:       return 9;
            3:       return 10;
            4:       return 12;
            5:       return 13;
            default: return 14;
        endcase
    endfunction

    // source number served by a peripheral event line
    function automatic int evt_src(input int e);
        case (e)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            6:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_TOP - (VEC_W'(idx) << 1);
    endfunction

endpackage

// File: rtl/ipc_edge_unit.sv
module ipc_edge_unit
    import ipc_pkg::*;
#(
    parameter int N      = NUM_PIN,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] hit
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] sync_q;
        logic              eff;
        logic              eff_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                eff_q  <= 1'b0;
            end else begin
                sync_q <= {sync_q[STAGES-2:0], pin[g]};
                eff_q  <= eff;
            end
        end

        // polarity applied after the synchronizer: a select flip acts as a level step
        assign eff    = sync_q[STAGES-1] ^ fall_sel[g];
        assign hit[g] = eff & ~eff_q;
    end

endmodule

// File: rtl/ipc_reg_bank.sv
module ipc_reg_bank
    import ipc_pkg::*;
#(
    parameter int RW = REQ_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NP = NUM_PIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] set_vec,
    input  logic [RW-1:0] ack_clr,
    input  logic          accept,
    output logic [RW-1:0] pend,
    output logic [RW-1:0] ena,
    output logic [NP-1:0] fall_sel,
    output logic          mask,
    output logic [DW-1:0] rdata
);

    localparam int HI_W = RW - DW;

    logic [RW-1:0] sw_clr;
    logic          wr_plo, wr_phi, wr_elo, wr_ehi, wr_edge, wr_mask;

    always_comb begin
        wr_plo  = wr && (addr == REG_PEND_LO);
        wr_phi  = wr && (addr == REG_PEND_HI);
        wr_elo  = wr && (addr == REG_ENA_LO);
        wr_ehi  = wr && (addr == REG_ENA_HI);
        wr_edge = wr && (addr == REG_EDGE);
        wr_mask = wr && (addr == REG_MASK);
    end

    always_comb begin
        sw_clr = '0;
        if (wr_plo) sw_clr[DW-1:0]  = ~wdata;
        if (wr_phi) sw_clr[RW-1:DW] = ~wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            ena      <= '0;
            fall_sel <= '0;
            mask     <= 1'b1;
        end else begin
            // new events win over any same-cycle clear
            pend <= (pend & ~(sw_clr | ack_clr)) | set_vec;
            if (wr_elo)  ena[DW-1:0]  <= wdata;
            if (wr_ehi)  ena[RW-1:DW] <= wdata[HI_W-1:0];
            if (wr_edge) fall_sel     <= wdata[NP-1:0];
            if (accept)       mask <= 1'b1;
            else if (wr_mask) mask <= wdata[0];
        end
    end

    always_comb begin
        case (addr)
            REG_PEND_LO: rdata = pend[DW-1:0];
            REG_PEND_HI: rdata = DW'(pend[RW-1:DW]);
            REG_ENA_LO:  rdata = ena[DW-1:0];
            REG_ENA_HI:  rdata = DW'(ena[RW-1:DW]);
            REG_EDGE:    rdata = DW'(fall_sel);
            REG_MASK:    rdata = DW'(mask);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int RW = REQ_W
) (
    input  logic          boot,
    input  logic          brk,
    input  logic          mask,
    input  logic [RW-1:0] pend,
    input  logic [RW-1:0] ena,
    output pick_t         pick
);

    logic [RW-1:0]    live;
    logic [SRC_W-1:0] low_idx;

    assign live = pend & ena;

    // descending scan: the lowest live source is assigned last and wins
    always_comb begin
        low_idx = '0;
        for (int i = RW - 1; i >= 0; i--) begin
            if (live[i]) low_idx = SRC_W'(i + 1);
        end
    end

    always_comb begin
        pick = '0;
        if (boot) begin
            pick.valid   = 1'b1;
            pick.is_boot = 1'b1;
            pick.idx     = '0;
        end else if (brk) begin
            pick.valid  = 1'b1;
            pick.is_brk = 1'b1;
            pick.idx    = BRK_SLOT;
        end else if (!mask && (live != '0)) begin
            pick.valid = 1'b1;
            pick.idx   = low_idx;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int NP = NUM_PIN,
    parameter int NE = NUM_EVT,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NP-1:0] ext_pin,
    input  logic [NE-1:0] periph_evt,
    input  logic          brk_req,
    input  logic          cpu_ack,
    output logic          irq,
    output logic [VW-1:0] vec_addr
);

    logic [NP-1:0]    pin_hit;
    logic [NP-1:0]    fall_sel;
    logic [REQ_W-1:0] set_vec;
    logic [REQ_W-1:0] ack_clr;
    logic [REQ_W-1:0] req_q;
    logic [REQ_W-1:0] en_q;
    logic             dis;
    logic             boot_pend;
    logic             brk_pend;
    logic             accept;
    pick_t            pick;

    ipc_edge_unit #(.N(NP), .STAGES(SYNC_DEPTH)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .fall_sel (fall_sel),
        .hit      (pin_hit)
    );

    always_comb begin
        set_vec = '0;
        for (int p = 0; p < NP; p++)
            set_vec[pin_src(p) - 1] = set_vec[pin_src(p) - 1] | pin_hit[p];
        for (int e = 0; e < NE; e++)
            set_vec[evt_src(e) - 1] = set_vec[evt_src(e) - 1] | periph_evt[e];
    end

    assign accept = cpu_ack & pick.valid;

    always_comb begin
        ack_clr = '0;
        if (accept && !pick.is_boot && !pick.is_brk)
            ack_clr[pick.idx - 1'b1] = 1'b1;
    end

    ipc_reg_bank #(.RW(REQ_W), .DW(DW), .AW(AW), .NP(NP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .set_vec  (set_vec),
        .ack_clr  (ack_clr),
        .accept   (accept),
        .pend     (req_q),
        .ena      (en_q),
        .fall_sel (fall_sel),
        .mask     (dis),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_pend <= 1'b1;
            brk_pend  <= 1'b0;
        end else begin
            if (accept && pick.is_boot) boot_pend <= 1'b0;
            brk_pend <= brk_req | (brk_pend & ~(accept & pick.is_brk));
        end
    end

    ipc_arbiter #(.RW(REQ_W)) u_arb (
        .boot (boot_pend),
        .brk  (brk_pend),
        .mask (dis),
        .pend (req_q),
        .ena  (en_q),
        .pick (pick)
    );

    assign irq      = pick.valid;
    assign vec_addr = vec_of(pick.idx);

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic [15:0] vec_addr,
    input logic        cpu_ack,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_rdata,
    input logic        boot_pend,
    input logic        brk_pend,
    input logic        dis,
    input logic [14:0] req_q,
    input logic [14:0] en_q,
    input logic [14:0] set_vec
);

    a_r1_vector_window: assert property (@(posedge clk) disable iff (rst)
        irq |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFDE && vec_addr <= 16'hFFFC));

    a_r2_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (boot_pend || brk_pend || (!dis && ((req_q & en_q) != 15'd0))));

    a_r3_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        (((~req_q) & set_vec) == 15'd0) |=> ((req_q & ~$past(req_q)) == 15'd0));

    a_r4_break_vector: assert property (@(posedge clk) disable iff (rst)
        (brk_pend && !boot_pend) |-> (irq && vec_addr == 16'hFFDE));

    a_r5_accept_masks: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq) |=> dis);

    a_r8_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd1 || bus_addr == 3'd3) |-> !bus_rdata[7]);

    a_r9_boot_first: assert property (@(posedge clk) disable iff (rst)
        boot_pend |-> (irq && vec_addr == 16'hFFFC));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .vec_addr  (vec_addr),
    .cpu_ack   (cpu_ack),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .boot_pend (boot_pend),
    .brk_pend  (brk_pend),
    .dis       (dis),
    .req_q     (req_q),
    .en_q      (en_q),
    .set_vec   (set_vec)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [6:0]  ext_pin = '0;
    logic [7:0]  periph_evt = '0;
    logic        brk_req = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        irq;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [14:0] m_req, m_en;
    logic        m_dis, m_boot, m_brk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_pin    (ext_pin),
        .periph_evt (periph_evt),
        .brk_req    (brk_req),
        .cpu_ack    (cpu_ack),
        .irq        (irq),
        .vec_addr   (vec_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        periph_evt = m;
        tick();
        periph_evt = '0;
    endtask

    task automatic pulse_ack();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
    endtask

    task automatic pulse_brk();
        brk_req = 1'b1;
        tick();
        brk_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_wr = 0; periph_evt = '0; brk_req = 0; cpu_ack = 0; ext_pin = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int evt_bit(input int e);
        case (e)
            0: return 2;  1: return 3;  2: return 4;  3: return 5;
            4: return 6;  5: return 7;  6: return 10; default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] e_idx();
        for (int i = 0; i < 15; i++)
            if (m_req[i] && m_en[i]) return 4'(i + 1);
        return 4'd0;
    endfunction

    function automatic logic e_irq();
        return m_boot || m_brk || (!m_dis && ((m_req & m_en) != 15'd0));
    endfunction

    function automatic logic [15:0] e_vec();
        if (m_boot) return 16'hFFFC;
        if (m_brk)  return 16'hFFDE;
        return 16'hFFFC - 16'(2 * e_idx());
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_req[7:0];
            3'd1: return {1'b0, m_req[14:8]};
            3'd2: return m_en[7:0];
            3'd3: return {1'b0, m_en[14:8]};
            3'd5: return {7'd0, m_dis};
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R9 reset state
        check("R9 irq", irq, 1'b1);
        check("R9 vec", vec_addr, 16'hFFFC);
        chk_reg("R9 pend lo", 3'd0, 8'h00);
        chk_reg("R9 ena lo", 3'd2, 8'h00);
        chk_reg("R9 edge", 3'd4, 8'h00);
        chk_reg("R9 mask", 3'd5, 8'h01);
        pulse_ack();
        check("R9 boot cleared", irq, 1'b0);
        chk_reg("R5 mask stays", 3'd5, 8'h01);

        // R8
        wr_reg(3'd3, 8'hFF);
        chk_reg("R8 ena hi", 3'd3, 8'h7F);

        // R10 / R2
        pulse_evt(8'h04);
        chk_reg("R10 pend lo", 3'd0, 8'h10);
        check("R2 masked", irq, 1'b0);
        wr_reg(3'd5, 8'h00);
        check("R2 not enabled", irq, 1'b0);
        wr_reg(3'd2, 8'hFF);
        check("R2 irq", irq, 1'b1);
        check("R1 vec src5", vec_addr, 16'hFFF2);

        // R3
        wr_reg(3'd0, 8'hFF);
        chk_reg("R3 write one keeps", 3'd0, 8'h10);
        wr_reg(3'd0, 8'hEF);
        chk_reg("R3 write zero clears", 3'd0, 8'h00);
        check("R3 irq drops", irq, 1'b0);

        // R1 priority, R5 accept
        pulse_evt(8'h81);
        check("R1 vec src3", vec_addr, 16'hFFF6);
        pulse_ack();
        check("R5 masked after accept", irq, 1'b0);
        chk_reg("R5 src3 cleared", 3'd0, 8'h00);
        chk_reg("R5 src15 kept", 3'd1, 8'h40);
        wr_reg(3'd5, 8'h00);
        check("R1 vec src15", vec_addr, 16'hFFDE);
        pulse_ack();
        chk_reg("R5 src15 cleared", 3'd1, 8'h00);
        pulse_ack();
        chk_reg("R5 ack idle no effect", 3'd5, 8'h01);

        // R4 break
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd3, 8'h00);
        pulse_brk();
        check("R4 irq", irq, 1'b1);
        check("R4 vec", vec_addr, 16'hFFDE);
        pulse_ack();
        check("R4 break cleared", irq, 1'b0);
        wr_reg(3'd2, 8'hFF);
        pulse_evt(8'h01);
        wr_reg(3'd5, 8'h00);
        check("R4 maskable vec", vec_addr, 16'hFFF6);
        pulse_brk();
        check("R4 break wins", vec_addr, 16'hFFDE);
        pulse_ack();
        check("R4 masked after", irq, 1'b0);
        chk_reg("R4 maskable kept", 3'd0, 8'h04);
        wr_reg(3'd0, 8'h00);

        // R6 rising on pin 0
        ext_pin[0] = 1'b1;
        tick(); tick();
        chk_reg("R6 not yet", 3'd0, 8'h00);
        tick();
        chk_reg("R6 rise latched", 3'd0, 8'h01);
        wr_reg(3'd0, 8'h00);
        ext_pin[0] = 1'b0;
        repeat (4) tick();
        chk_reg("R6 fall ignored", 3'd0, 8'h00);

        // R7 spurious on select flip (pin 1 low, switch to falling)
        wr_reg(3'd4, 8'h02);
        chk_reg("R7 not yet", 3'd0, 8'h00);
        tick();
        chk_reg("R7 spurious set", 3'd0, 8'h02);
        wr_reg(3'd0, 8'h00);
        ext_pin[1] = 1'b1;
        repeat (4) tick();
        chk_reg("R6 rise ignored when falling", 3'd0, 8'h00);
        ext_pin[1] = 1'b0;
        tick(); tick();
        chk_reg("R6 fall not yet", 3'd0, 8'h00);
        tick();
        chk_reg("R6 fall latched", 3'd0, 8'h02);
        wr_reg(3'd0, 8'h00);

        // pin 2 -> source 9
        ext_pin[2] = 1'b1;
        repeat (3) tick();
        chk_reg("R6 pin2 src9", 3'd1, 8'h01);

        // R10 set beats same-cycle clear
        periph_evt = 8'h10;
        wr_reg(3'd0, 8'h00);
        periph_evt = '0;
        chk_reg("R10 set wins", 3'd0, 8'h40);

        // random phase against the reference state
        do_reset();
        m_req = '0; m_en = '0; m_dis = 1'b1; m_boot = 1'b1; m_brk = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            logic [2:0]  ra, wa;
            logic [7:0]  ev, wd;
            logic        b, a, w, acc;
            logic [14:0] clr, setv;
            logic [3:0]  idx;
            ra = 3'($urandom_range(0, 5));
            bus_addr = ra;
            #1;
            check("R2 rand irq", irq, e_irq());
            if (e_irq()) check("R1 rand vec", vec_addr, e_vec());
            check("R3 rand read", bus_rdata, m_read(ra));

            ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
            b  = ($urandom_range(0, 24) == 0);
            a  = irq ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 19) == 0);
            w  = ($urandom_range(0, 4) == 0);
            wa = 3'($urandom_range(0, 4));
            if (wa == 3'd4) wa = 3'd5;
            wd = 8'($urandom);

            periph_evt = ev; brk_req = b; cpu_ack = a;
            bus_wr = w; bus_addr = wa; bus_wdata = wd;

            acc = a && e_irq();
            idx = e_idx();
            clr = '0;
            if (w && wa == 3'd0) clr[7:0]  = ~wd;
            if (w && wa == 3'd1) clr[14:8] = ~wd[6:0];
            if (acc && !m_boot && !m_brk) clr[idx - 1] = 1'b1;
            setv = '0;
            for (int e = 0; e < 8; e++) if (ev[e]) setv[evt_bit(e)] = 1'b1;

            if (acc && m_boot)       m_boot = 1'b0;
            else if (acc && m_brk)   m_brk  = 1'b0;
            m_brk = m_brk | b;
            m_req = (m_req & ~clr) | setv;
            if (w && wa == 3'd2) m_en[7:0]  = wd;
            if (w && wa == 3'd3) m_en[14:8] = wd[6:0];
            if (acc)                   m_dis = 1'b1;
            else if (w && wa == 3'd5)  m_dis = wd[0];

            tick();
            periph_evt = '0; brk_req = 0; cpu_ack = 0; bus_wr = 0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule